// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block holds the working state of one DMA channel: a source address, a destination address, a transfer counter and a block counter, each with a saved copy that can be restored. Each time the bus side reports that a transfer unit has completed, the block moves both addresses by their configured signed step and counts the unit down. The size of the data unit, the direction of each address and the way requests turn into units are all configurable.

Software programs the channel through a small register port. A request input starts work, and a unit-done strobe reports each granted unit. The block raises a "wants a unit" output whenever it has work. Requests map to units in one of four ways: a single unit per request, a run to completion, a whole block per request, or units for as long as the request is held. On the last unit the block pulses an end-of-operation output. It then either disables the channel or restores its registers from the saved copies.

Top module: `dma_seq`

## Requirements
- R1: After reset both addresses read zero, and the channel enable, want and end-of-operation outputs are low.
- R2: A write with `cfg_sel`=0 loads the source address (working and saved copy), and `cfg_sel`=1 does the same for the destination address. `cfg_sel`=2 loads the transfer count from bits [15:0] and the block count from bits [19:16]. `cfg_sel`=3 loads the control word: enable [0], mode [2:1], reload [3], unit size [5:4], source direction [7:6], destination direction [9:8], source step [17:10] and destination step [25:18].
- R3: On each granted unit, an address with direction 1 increases and one with direction 2 decreases by its step value. A step value of 0 instead uses the unit size: 1 byte for size 0, 2 bytes for size 1, 4 bytes for size 2.
- R4: An address with direction 0 does not change on granted units.
- R5: In mode 1 (single), one request pulse makes `unit_want` high for exactly one granted unit.
- R6: In mode 2 (run), one request pulse keeps `unit_want` high until the transfer count is used up.
- R7: In mode 3 (block), one request pulse grants a full block of units and then decrements the transfer count by one. A block count of 0 means 16 units.
- R8: In mode 0 (follow), `unit_want` equals the request input while the channel is enabled.
- R9: `eop` is high for one cycle, in the cycle after the unit that ends the transfer count.
- R10: With reload clear, the channel enable clears when the transfer ends, and later requests produce no units.
- R11: With reload set, both addresses and the counts return to their saved values when the transfer ends. The channel stays enabled and waits for a new request.
- R12: A programmed transfer count of 0 gives 65536 units.
- R13: A `unit_done` strobe while `unit_want` is low changes no address or count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| xfer_req | input | 1 | Transfer request |
| unit_done | input | 1 | A transfer unit was granted and completed |
| unit_want | output | 1 | Channel has a unit to move |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| eop | output | 1 | End-of-operation pulse |
| chan_en | output | 1 | Channel enable state |

## Verification
The bench uses the default parameters: 32-bit addresses, a 16-bit transfer count, a 4-bit block count and 8-bit step values. With these values the 16-unit wrap of a zero block count is reached with a single request. The 65536-unit case of a zero transfer count fits inside one run-mode transfer. The 8-bit steps allow the bench to use both a step of zero (the unit size applies) and explicit step values.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    MODE_DEMAND = 2'd0,
    MODE_STEP   = 2'd1,
    MODE_BURST  = 2'd2,
    MODE_BLOCK  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    DIR_FIXED = 2'd0,
    DIR_INC   = 2'd1,
    DIR_DEC   = 2'd2,
    DIR_HOLD  = 2'd3
  } addr_dir_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } unit_size_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          restore_i,
  input  addr_dir_e     dir_i,
  input  logic [MW-1:0] mag_i,
  input  unit_size_e    size_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] rld_q, rld_d;
  logic [AW-1:0] off;

  // step amount: explicit magnitude, or the unit size when it is zero
  always_comb begin
    if (mag_i != '0) begin
      off = AW'(mag_i);
    end else begin
      case (size_i)
        SZ_BYTE: off = AW'(1);
        SZ_HALF: off = AW'(2);
        default: off = AW'(4);
      endcase
    end
  end

  always_comb begin
    cur_d = cur_q;
    rld_d = rld_q;
    if (load_i) begin
      cur_d = load_val_i;
      rld_d = load_val_i;
    end else if (restore_i) begin
      cur_d = rld_q;
    end else if (step_i) begin
      case (dir_i)
        DIR_INC: cur_d = cur_q + off;
        DIR_DEC: cur_d = cur_q - off;
        default: cur_d = cur_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      rld_q <= '0;
    end else begin
      cur_q <= cur_d;
      rld_q <= rld_d;
    end
  end

  assign addr_o = cur_q;

  // R4: a fixed address ignores granted units
  p_fixed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !restore_i && dir_i == DIR_FIXED) |=> $stable(addr_o));

endmodule

// File: rtl/dma_count_reg.sv
module dma_count_reg #(
  parameter int CW = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_cnt_i,
  input  logic [BW-1:0] load_blk_i,
  input  logic          dec_i,
  input  logic          blk_mode_i,
  input  logic          restore_i,
  output logic          blk_end_o,
  output logic          last_o
);

  logic [CW-1:0] cnt_q, cnt_d, cnt_rld_q, cnt_rld_d;
  logic [BW-1:0] blk_cfg_q, blk_cfg_d, blk_rem_q, blk_rem_d;

  // a zero block setting wraps through all 2**BW values before ending
  assign blk_end_o = !blk_mode_i || (blk_rem_q == BW'(1));
  assign last_o    = blk_end_o && (cnt_q == CW'(1));

  always_comb begin
    cnt_d     = cnt_q;
    cnt_rld_d = cnt_rld_q;
    blk_cfg_d = blk_cfg_q;
    blk_rem_d = blk_rem_q;
    if (load_i) begin
      cnt_d     = load_cnt_i;
      cnt_rld_d = load_cnt_i;
      blk_cfg_d = load_blk_i;
      blk_rem_d = load_blk_i;
    end else if (restore_i) begin
      cnt_d     = cnt_rld_q;
      blk_rem_d = blk_cfg_q;
    end else if (dec_i) begin
      if (blk_mode_i) begin
        if (blk_rem_q == BW'(1)) begin
          blk_rem_d = blk_cfg_q;
          cnt_d     = cnt_q - CW'(1);
        end else begin
          blk_rem_d = blk_rem_q - BW'(1);
        end
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cnt_rld_q <= '0;
      blk_cfg_q <= '0;
      blk_rem_q <= '0;
    end else begin
      cnt_q     <= cnt_d;
      cnt_rld_q <= cnt_rld_d;
      blk_cfg_q <= blk_cfg_d;
      blk_rem_q <= blk_rem_d;
    end
  end

  // R7: inside a block the transfer count holds
  p_blk_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && blk_mode_i && !load_i && !restore_i && blk_rem_q != BW'(1))
    |=> $stable(cnt_q));

endmodule

// File: rtl/dma_seq_ctl.sv
module dma_seq_ctl
  import dma_seq_pkg::*;
#(
  parameter  int MW     = 8,
  localparam int CTRL_W = 10 + 2 * MW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              req_i,
  input  logic              done_i,
  input  logic              blk_end_i,
  input  logic              last_i,
  output logic              en_o,
  output xfer_mode_e        mode_o,
  output logic              reload_o,
  output unit_size_e        size_o,
  output addr_dir_e         src_dir_o,
  output addr_dir_e         dst_dir_o,
  output logic [MW-1:0]     src_mag_o,
  output logic [MW-1:0]     dst_mag_o,
  output logic              load_src_o,
  output logic              load_dst_o,
  output logic              load_cnt_o,
  output logic              want_o,
  output logic              fire_o,
  output logic              term_o,
  output logic              eop_o
);

  localparam int SMAG_LSB = 10;
  localparam int DMAG_LSB = 10 + MW;

  logic       ctrl_wr;
  logic       en_q, en_d;
  logic       pend_q, pend_d;
  logic       eop_q;
  logic       quantum_end;
  xfer_mode_e mode_q;
  logic       reload_q;
  unit_size_e size_q;
  addr_dir_e  sdir_q, ddir_q;
  logic [MW-1:0] smag_q, dmag_q;

  assign ctrl_wr    = cfg_we_i && (cfg_sel_i == SEL_CTRL);
  assign load_src_o = cfg_we_i && (cfg_sel_i == SEL_SRC);
  assign load_dst_o = cfg_we_i && (cfg_sel_i == SEL_DST);
  assign load_cnt_o = cfg_we_i && (cfg_sel_i == SEL_CNT);

  assign want_o = en_q && ((mode_q == MODE_DEMAND) ? req_i : pend_q);
  assign fire_o = want_o && done_i;
  assign term_o = fire_o && last_i;

  // the unit that closes the work owed to one request
  always_comb begin
    case (mode_q)
      MODE_STEP:  quantum_end = 1'b1;
      MODE_BLOCK: quantum_end = blk_end_i;
      default:    quantum_end = 1'b0;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (ctrl_wr) begin
      pend_d = 1'b0;
    end else if (fire_o && (term_o || quantum_end)) begin
      pend_d = 1'b0;
    end else if (en_q && req_i && mode_q != MODE_DEMAND && !fire_o) begin
      pend_d = 1'b1;
    end
  end

  always_comb begin
    en_d = en_q;
    if (ctrl_wr) begin
      en_d = ctrl_i[0];
    end else if (term_o && !reload_q) begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
      eop_q    <= 1'b0;
      mode_q   <= MODE_DEMAND;
      reload_q <= 1'b0;
      size_q   <= SZ_BYTE;
      sdir_q   <= DIR_FIXED;
      ddir_q   <= DIR_FIXED;
      smag_q   <= '0;
      dmag_q   <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      eop_q  <= term_o;
      if (ctrl_wr) begin
        mode_q   <= xfer_mode_e'(ctrl_i[2:1]);
        reload_q <= ctrl_i[3];
        size_q   <= unit_size_e'(ctrl_i[5:4]);
        sdir_q   <= addr_dir_e'(ctrl_i[7:6]);
        ddir_q   <= addr_dir_e'(ctrl_i[9:8]);
        smag_q   <= ctrl_i[SMAG_LSB +: MW];
        dmag_q   <= ctrl_i[DMAG_LSB +: MW];
      end
    end
  end

  assign en_o      = en_q;
  assign mode_o    = mode_q;
  assign reload_o  = reload_q;
  assign size_o    = size_q;
  assign src_dir_o = sdir_q;
  assign dst_dir_o = ddir_q;
  assign src_mag_o = smag_q;
  assign dst_mag_o = dmag_q;
  assign eop_o     = eop_q;

  // R5: a single-unit request is finished after its one unit
  p_step_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && mode_q == MODE_STEP && !cfg_we_i) |=> !want_o);

  // R10: end of a one-shot transfer leaves the channel disabled
  p_single_shot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_q && !reload_q && !$past(cfg_we_i)) |-> !en_q);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BW = 4,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          xfer_req,
  input  logic          unit_done,
  output logic          unit_want,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          eop,
  output logic          chan_en
);

  localparam int CTRL_W = 10 + 2 * MW;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  xfer_mode_e    mode;
  unit_size_e    size;
  addr_dir_e     src_dir, dst_dir;
  logic [MW-1:0] src_mag, dst_mag;
  logic          reload, load_src, load_dst, load_cnt;
  logic          fire, term, blk_end, last, restore;

  assign restore = term && reload;

  dma_seq_ctl #(.MW(MW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cfg_we_i   (cfg_we),
    .cfg_sel_i  (cfg_sel),
    .ctrl_i     (cfg_wdata[CTRL_W-1:0]),
    .req_i      (xfer_req),
    .done_i     (unit_done),
    .blk_end_i  (blk_end),
    .last_i     (last),
    .en_o       (chan_en),
    .mode_o     (mode),
    .reload_o   (reload),
    .size_o     (size),
    .src_dir_o  (src_dir),
    .dst_dir_o  (dst_dir),
    .src_mag_o  (src_mag),
    .dst_mag_o  (dst_mag),
    .load_src_o (load_src),
    .load_dst_o (load_dst),
    .load_cnt_o (load_cnt),
    .want_o     (unit_want),
    .fire_o     (fire),
    .term_o     (term),
    .eop_o      (eop)
  );

  dma_count_reg #(.CW(CW), .BW(BW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (load_cnt),
    .load_cnt_i (cfg_wdata[CW-1:0]),
    .load_blk_i (cfg_wdata[CW +: BW]),
    .dec_i      (fire),
    .blk_mode_i (mode == MODE_BLOCK),
    .restore_i  (restore),
    .blk_end_o  (blk_end),
    .last_o     (last)
  );

  logic [1:0]    a_load;
  addr_dir_e     a_dir [2];
  logic [MW-1:0] a_mag [2];
  logic [AW-1:0] a_out [2];

  assign a_load   = {load_dst, load_src};
  assign a_dir[0] = src_dir;
  assign a_dir[1] = dst_dir;
  assign a_mag[0] = src_mag;
  assign a_mag[1] = dst_mag;

  for (genvar g = 0; g < 2; g++) begin : g_addr
    dma_addr_reg #(.AW(AW), .MW(MW)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .load_i     (a_load[g]),
      .load_val_i (cfg_wdata),
      .step_i     (fire),
      .restore_i  (restore),
      .dir_i      (a_dir[g]),
      .mag_i      (a_mag[g]),
      .size_i     (size),
      .addr_o     (a_out[g])
    );
  end

  assign src_addr = a_out[0];
  assign dst_addr = a_out[1];

  // R13: strobes without a pending unit leave the addresses alone
  p_idle_ignore_r13: assert property (@(posedge clk) disable iff (!rst_n_s)
    (unit_done && !unit_want && !cfg_we) |=> ($stable(src_addr) && $stable(dst_addr)));

endmodule

// File: tb/dma_seq_tb.sv
`timescale 1ns/1ps
module dma_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        xfer_req;
  logic        unit_done;
  logic        unit_want;
  logic [31:0] src_addr, dst_addr;
  logic        eop, chan_en;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  dma_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .xfer_req(xfer_req), .unit_done(unit_done),
    .unit_want(unit_want), .src_addr(src_addr), .dst_addr(dst_addr),
    .eop(eop), .chan_en(chan_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input logic en, input logic [1:0] mode,
      input logic rl, input logic [1:0] sz, input logic [1:0] sdir,
      input logic [1:0] ddir, input logic [7:0] smag, input logic [7:0] dmag);
    return {6'd0, dmag, smag, ddir, sdir, sz, rl, mode, en};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
  endtask

  task automatic count_units(input int cycles, output int nf, output int ne);
    nf = 0; ne = 0;
    #1;
    repeat (cycles) begin
      if (unit_want && unit_done) nf++;
      if (eop) ne++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_reset();
    chk("R1 src", src_addr, 0);
    chk("R1 dst", dst_addr, 0);
    chk("R1 en", chan_en, 0);
    chk("R1 want", unit_want, 0);
    chk("R1 eop", eop, 0);
  endtask

  task automatic t_step();
    wr(2'd0, 32'h1000);
    wr(2'd1, 32'h2000);
    #1;
    chk("R2 src load", src_addr, 32'h1000);
    chk("R2 dst load", dst_addr, 32'h2000);
    wr(2'd2, 32'd5);
    wr(2'd3, mk_ctrl(1, 2'd1, 0, 2'd2, 2'd1, 2'd2, 8'd0, 8'd3));
    pulse_req();
    #1 chk("R5 want after request", unit_want, 1);
    unit_done = 1'b1;
    @(negedge clk); #1;
    unit_done = 1'b0;
    chk("R3 src inc word size", src_addr, 32'h1004);
    chk("R3 dst dec by 3", dst_addr, 32'h1FFD);
    chk("R5 want after one unit", unit_want, 0);
    unit_done = 1'b1;
    repeat (3) @(negedge clk);
    unit_done = 1'b0; #1;
    chk("R13 src idle strobe", src_addr, 32'h1004);
    chk("R13 dst idle strobe", dst_addr, 32'h1FFD);
    wr(2'd3, mk_ctrl(1, 2'd1, 0, 2'd1, 2'd0, 2'd1, 8'd7, 8'd0));
    pulse_req();
    unit_done = 1'b1;
    @(negedge clk); #1;
    unit_done = 1'b0;
    chk("R4 fixed src", src_addr, 32'h1004);
    chk("R3 dst inc half size", dst_addr, 32'h1FFF);
  endtask

  task automatic t_burst();
    int nf, ne;
    wr(2'd0, 32'h300);
    wr(2'd1, 32'h400);
    wr(2'd2, 32'd3);
    wr(2'd3, mk_ctrl(1, 2'd2, 0, 2'd0, 2'd1, 2'd0, 8'd0, 8'd0));
    unit_done = 1'b1;
    pulse_req();
    count_units(8, nf, ne);
    chk("R6 run units", nf, 3);
    chk("R9 eop pulses", ne, 1);
    chk("R3 src byte steps", src_addr, 32'h303);
    chk("R4 dst fixed", dst_addr, 32'h400);
    chk("R10 enable cleared", chan_en, 0);
    pulse_req();
    count_units(4, nf, ne);
    chk("R10 request ignored", nf, 0);
    unit_done = 1'b0;
  endtask

  task automatic t_block();
    int nf, ne;
    wr(2'd0, 32'h500);
    wr(2'd2, 32'd2);
    wr(2'd3, mk_ctrl(1, 2'd3, 0, 2'd2, 2'd1, 2'd0, 8'd0, 8'd0));
    unit_done = 1'b1;
    pulse_req();
    count_units(24, nf, ne);
    chk("R7 zero block is 16", nf, 16);
    chk("R7 no eop mid count", ne, 0);
    chk("R7 src after block", src_addr, 32'h540);
    pulse_req();
    count_units(24, nf, ne);
    chk("R7 second block", nf, 16);
    chk("R9 eop after last block", ne, 1);
    wr(2'd2, (32'd3 << 16) | 32'd1);
    wr(2'd3, mk_ctrl(1, 2'd3, 0, 2'd2, 2'd1, 2'd0, 8'd0, 8'd0));
    pulse_req();
    count_units(8, nf, ne);
    chk("R7 block of three", nf, 3);
    chk("R9 eop block of three", ne, 1);
    unit_done = 1'b0;
  endtask

  task automatic t_demand();
    int nf, ne;
    wr(2'd0, 32'h600);
    wr(2'd2, 32'd10);
    wr(2'd3, mk_ctrl(1, 2'd0, 0, 2'd0, 2'd1, 2'd0, 8'd0, 8'd0));
    unit_done = 1'b1;
    @(negedge clk);
    xfer_req = 1'b1; #1;
    chk("R8 want follows high", unit_want, 1);
    count_units(4, nf, ne);
    xfer_req = 1'b0; #1;
    chk("R8 held units", nf, 4);
    chk("R8 want follows low", unit_want, 0);
    count_units(3, nf, ne);
    chk("R8 no units when low", nf, 0);
    chk("R8 src moved", src_addr, 32'h604);
    unit_done = 1'b0;
  endtask

  task automatic t_reload();
    int nf, ne;
    wr(2'd0, 32'h100);
    wr(2'd1, 32'h800);
    wr(2'd2, 32'd2);
    wr(2'd3, mk_ctrl(1, 2'd2, 1, 2'd2, 2'd1, 2'd2, 8'd0, 8'd0));
    unit_done = 1'b1;
    pulse_req();
    count_units(6, nf, ne);
    chk("R11 first run units", nf, 2);
    chk("R11 first eop", ne, 1);
    chk("R11 src restored", src_addr, 32'h100);
    chk("R11 dst restored", dst_addr, 32'h800);
    chk("R11 still enabled", chan_en, 1);
    pulse_req();
    count_units(6, nf, ne);
    chk("R11 count restored", nf, 2);
    chk("R11 second eop", ne, 1);
    unit_done = 1'b0;
  endtask

  task automatic t_zero_count();
    int nf, ne;
    wr(2'd2, 32'd0);
    wr(2'd3, mk_ctrl(1, 2'd2, 0, 2'd0, 2'd0, 2'd0, 8'd0, 8'd0));
    unit_done = 1'b1;
    pulse_req();
    count_units(65540, nf, ne);
    chk("R12 zero count units", nf, 65536);
    chk("R12 single eop", ne, 1);
    unit_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    xfer_req = 1'b0; unit_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    t_step();
    t_burst();
    t_block();
    t_demand();
    t_reload();
    t_zero_count();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule